// File: doc/BRIEF.md
# SD host normal interrupt status unit

This block holds the sixteen-bit normal interrupt status word of an SD/MMC host controller. The controller core reports events as one-cycle pulses. The block latches each pulse into its own status bit and holds it until software writes a 1 to that bit. Two bits follow other rules. Bit 15 is a read-only summary that is set while any bit of a separate error status word is set. Bit 8 follows the level of the card's interrupt line, and software cannot clear it.

Two masks act on the word. The status enable mask decides what a read returns, and whether an incoming event is recorded at all. The signal enable mask never changes a read. It only selects which visible status bits drive the single registered interrupt output. The register port has a write strobe with write data and a combinational read.

Top module: `sd_irq_status`

## Requirements
- R1: After reset every status bit reads 0 and `irq_out` is 0.
- R2: A pulse on `ev_std[k]` sets status bit k (k = 0..7), and a pulse on `ev_aux[j]` sets status bit 9+j (j = 0..5). The bit reads 1 from the cycle after the pulse when its `stat_en` bit is 1.
- R3: An event that arrives while its `stat_en` bit is 0 is dropped. The bit still reads 0 after the enable is set again.
- R4: `reg_rdata` equals the status word ANDed with `stat_en`. A latched bit that is hidden by `stat_en` keeps its value and reads 1 again once it is re-enabled.
- R5: A write with `reg_wr` high clears every event bit (bits 14..9 and 7..0) whose `reg_wdata` bit is 1. Bits written 0 are unchanged. Any number of bits can clear in one write.
- R6: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R7: Bit 15 reads 1 whenever any bit of `err_stat` is 1 and `stat_en[15]` is 1. Writes do not change it.
- R8: Bit 8 reads the level of `card_irq` as it was one cycle earlier (gated by `stat_en[8]`). Writing 1 to it has no effect. It returns to 0 only when `card_irq` falls.
- R9: `sig_en` has no effect on `reg_rdata`.
- R10: `irq_out` is 1 in a cycle exactly when, in the previous cycle, some bit of `reg_rdata` was 1 and its `sig_en` bit was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 16 | Write data; a 1 clears the matching event bit |
| reg_rdata | output | 16 | Visible status word (combinational) |
| stat_en | input | 16 | Status enable mask |
| sig_en | input | 16 | Signal enable mask for the interrupt output |
| ev_std | input | 8 | Event pulses for status bits 7..0 |
| ev_aux | input | 6 | Event pulses for status bits 14..9 |
| err_stat | input | ERR_W | Separate error status word |
| card_irq | input | 1 | Card interrupt level |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The case that needs care is a new event pulse landing in the same cycle as a write that clears the same bit. The bench sweeps every event bit. For each one it first sets the bit, then drives its pulse together with a write-1 to that bit in one cycle, and expects the bit to read 1 afterwards. A second write with no pulse must then clear it. Hidden-bit retention and masked-off events are provoked the same way, by changing `stat_en` between the event and the read. Every read is compared with a word the bench builds from the requirements.

// File: rtl/sdint_pkg.sv
package sdint_pkg;
  localparam int unsigned STS_W     = 16;
  localparam int unsigned ERR_POS   = 15;
  localparam int unsigned CARD_POS  = 8;
  localparam int unsigned STD_N     = 8;
  localparam int unsigned AUX_N     = 6;
  localparam int unsigned AUX_BASE  = 9;
  localparam logic [STS_W-1:0] W1C_MASK = 16'h7EFF;
endpackage

// File: rtl/sdint_rst_sync.sv
module sdint_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/sdint_w1c_bit.sv
module sdint_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic take_set;
  logic load;

  always_comb begin
    take_set = set_i & en_i;
    load     = take_set | clr_i;
    if (take_set)   q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
    else            q_d = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (load) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sdint_card_track.sv
module sdint_card_track (
  input  logic clk,
  input  logic rst_n,
  input  logic card_irq,
  output logic card_q
);
  logic lvl_q;
  logic lvl_d;
  logic chg;

  always_comb begin
    lvl_d = card_irq;
    chg   = lvl_d ^ lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lvl_q <= 1'b0;
    else if (chg) lvl_q <= lvl_d;
  end

  assign card_q = lvl_q;
endmodule

// File: rtl/sdint_irq_gen.sv
module sdint_irq_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vis_i,
  input  logic [W-1:0] sig_en,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(vis_i & sig_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sdint_pkg::*;
#(
  parameter int unsigned ERR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [15:0]      stat_en,
  input  logic [15:0]      sig_en,
  input  logic [7:0]       ev_std,
  input  logic [5:0]       ev_aux,
  input  logic [ERR_W-1:0] err_stat,
  input  logic             card_irq,
  output logic             irq_out
);
  logic             rst_s;
  logic [STS_W-1:0] sts_raw;
  logic [STS_W-1:0] sts_vis;
  logic [STS_W-1:0] clr_vec;
  logic             err_any;
  logic             card_q;
  logic             unused_wbits;

  sdint_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  always_comb begin
    clr_vec = reg_wr ? (reg_wdata & W1C_MASK) : '0;
    err_any = |err_stat;
  end

  assign unused_wbits = reg_wdata[ERR_POS] ^ reg_wdata[CARD_POS];

  sdint_card_track u_card (
    .clk      (clk),
    .rst_n    (rst_s),
    .card_irq (card_irq),
    .card_q   (card_q)
  );

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (i == ERR_POS) begin : g_err
      assign sts_raw[i] = err_any;
    end else if (i == CARD_POS) begin : g_card
      assign sts_raw[i] = card_q;
    end else if (i < STD_N) begin : g_std
      sdint_w1c_bit u_b (
        .clk   (clk),
        .rst_n (rst_s),
        .set_i (ev_std[i]),
        .en_i  (stat_en[i]),
        .clr_i (clr_vec[i]),
        .q_o   (sts_raw[i])
      );
    end else begin : g_aux
      sdint_w1c_bit u_b (
        .clk   (clk),
        .rst_n (rst_s),
        .set_i (ev_aux[i-AUX_BASE]),
        .en_i  (stat_en[i]),
        .clr_i (clr_vec[i]),
        .q_o   (sts_raw[i])
      );
    end
  end

  assign sts_vis   = sts_raw & stat_en;
  assign reg_rdata = sts_vis;

  sdint_irq_gen #(.W(STS_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_s),
    .vis_i  (sts_vis),
    .sig_en (sig_en),
    .irq_o  (irq_out)
  );
endmodule

// File: rtl/sdint_chk.sv
module sdint_chk
  import sdint_pkg::*;
#(
  parameter int unsigned ERR_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             reg_wr,
  input logic [15:0]      reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic [15:0]      stat_en,
  input logic [15:0]      sig_en,
  input logic [7:0]       ev_std,
  input logic [5:0]       ev_aux,
  input logic [ERR_W-1:0] err_stat,
  input logic             card_irq,
  input logic             irq_out,
  input logic [15:0]      sts_raw
);
  logic [15:0] set_req;
  logic        armed;

  always_comb begin
    set_req = {1'b0, ev_aux, 1'b0, ev_std} & stat_en & W1C_MASK;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4
  p_read_masked_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_rdata & ~stat_en) == 16'h0);

  // R5
  p_clear_w1_r5: assert property (@(posedge clk) disable iff (!rst_s)
    reg_wr |=> (sts_raw & $past(reg_wdata & W1C_MASK & ~set_req)) == 16'h0);

  // R5
  p_hold_w0_r5: assert property (@(posedge clk) disable iff (!rst_s)
    ((!reg_wr || reg_wdata == 16'h0) && set_req == 16'h0)
      |=> (sts_raw & W1C_MASK) == $past(sts_raw & W1C_MASK));

  // R6
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (set_req != 16'h0) |=> (sts_raw & $past(set_req)) == $past(set_req));

  // R7
  p_err_sum_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (err_stat != '0 && stat_en[ERR_POS]) |-> reg_rdata[ERR_POS]);

  // R8
  p_card_lvl_r8: assert property (@(posedge clk) disable iff (!rst_s)
    card_irq |=> (!stat_en[CARD_POS] || reg_rdata[CARD_POS]));

  // R10
  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_s)
    armed |-> irq_out == $past(|(reg_rdata & sig_en)));
endmodule

bind sd_irq_status sdint_chk #(.ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .stat_en   (stat_en),
  .sig_en    (sig_en),
  .ev_std    (ev_std),
  .ev_aux    (ev_aux),
  .err_stat  (err_stat),
  .card_irq  (card_irq),
  .irq_out   (irq_out),
  .sts_raw   (sts_raw)
);

// File: tb/sd_irq_status_tb.sv
`timescale 1ns/1ps
module sd_irq_status_tb;
  localparam int ERR_W = 16;
  localparam logic [15:0] EVM = 16'h7EFF;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr;
  logic [15:0]      reg_wdata;
  logic [15:0]      reg_rdata;
  logic [15:0]      stat_en;
  logic [15:0]      sig_en;
  logic [7:0]       ev_std;
  logic [5:0]       ev_aux;
  logic [ERR_W-1:0] err_stat;
  logic             card_irq;
  logic             irq_out;

  int total = 0;
  int bad   = 0;

  logic [15:0] m_raw;
  logic        m_card;
  logic        m_irq;

  always #2.5 clk = ~clk;

  sd_irq_status #(.ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stat_en(stat_en), .sig_en(sig_en),
    .ev_std(ev_std), .ev_aux(ev_aux), .err_stat(err_stat),
    .card_irq(card_irq), .irq_out(irq_out)
  );

  function automatic logic [15:0] ev_word();
    return {1'b0, ev_aux, 1'b0, ev_std};
  endfunction

  function automatic logic [15:0] exp_rd();
    logic [15:0] w;
    w = m_raw & EVM;
    w[15] = |err_stat;
    w[8]  = m_card;
    return w & stat_en;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic set_ev(input int p);
    if (p < 8) ev_std[p] = 1'b1;
    else       ev_aux[p-9] = 1'b1;
  endtask

  // One clock: update the model at the edge, drop pulses, compare.
  task automatic tick(input string tag);
    logic [15:0] clr;
    @(posedge clk);
    m_irq = |(exp_rd() & sig_en);
    clr   = reg_wr ? (reg_wdata & EVM) : 16'h0;
    m_raw = (ev_word() & stat_en & EVM) | (m_raw & ~clr & EVM);
    m_card = card_irq;
    #1;
    reg_wr = 1'b0; reg_wdata = 16'h0; ev_std = '0; ev_aux = '0;
    #1;
    chk({tag, " rdata"}, reg_rdata, exp_rd());
    chk({tag, " irq"}, {15'h0, irq_out}, {15'h0, m_irq});
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; stat_en = 16'hFFFF;
    sig_en = '0; ev_std = '0; ev_aux = '0; err_stat = '0; card_irq = 1'b0;
    m_raw = '0; m_card = 1'b0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    repeat (4) tick("R1");

    // R2 / R5: each event bit set, then cleared alone
    for (int p = 0; p < 15; p++) begin
      if (p == 8) continue;
      set_ev(p); tick("R2");
      wr(16'h1 << p); tick("R5");
    end

    // R3: events dropped while disabled
    for (int p = 0; p < 15; p++) begin
      if (p == 8) continue;
      stat_en = ~(16'h1 << p); set_ev(p); tick("R3");
      stat_en = 16'hFFFF; tick("R3");
    end

    // R4: hidden bit kept
    set_ev(3); ev_aux[2] = 1'b1; tick("R4");
    stat_en = 16'hFFF7; tick("R4");
    stat_en = 16'hFFFF; tick("R4");
    wr(16'hFFFF); tick("R5");

    // R5: write 0 keeps, multi-bit clear
    ev_std = 8'hFF; ev_aux = 6'h3F; tick("R5");
    wr(16'h0000); tick("R5");
    wr(16'h00F0); tick("R5");
    wr(16'h6C03); tick("R5");
    wr(16'hFFFF); tick("R5");

    // R6: set wins over same-cycle clear
    for (int p = 0; p < 15; p++) begin
      if (p == 8) continue;
      set_ev(p); tick("R6");
      set_ev(p); wr(16'h1 << p); tick("R6");
      wr(16'h1 << p); tick("R6");
    end

    // R7: error summary for each error bit, immune to writes
    for (int e = 0; e < ERR_W; e++) begin
      err_stat = '0; err_stat[e] = 1'b1; tick("R7");
    end
    wr(16'hFFFF); tick("R7");
    stat_en = 16'h7FFF; tick("R7");
    stat_en = 16'hFFFF; err_stat = '0; tick("R7");

    // R8: card level, write-immune, clears on fall
    card_irq = 1'b1; tick("R8"); tick("R8");
    wr(16'hFFFF); tick("R8");
    wr(16'h0100); tick("R8");
    card_irq = 1'b0; tick("R8"); tick("R8");

    // R9 / R10: sweep one-hot signal enables over a full status word
    ev_std = 8'hA5; ev_aux = 6'h2A; err_stat = 16'h0100; card_irq = 1'b1; tick("R9");
    for (int s = 0; s < 16; s++) begin
      sig_en = 16'h1 << s; tick("R9"); tick("R10");
    end
    sig_en = 16'hFFFF; stat_en = 16'h0000; tick("R10"); tick("R10");
    stat_en = 16'hFFFF; tick("R10");
    err_stat = '0; card_irq = 1'b0; wr(16'hFFFF); tick("R10"); tick("R10"); tick("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule